// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous request port and an external asynchronous static RAM with a 16-bit data bus and byte lanes. Each accepted request becomes one access cycle on the memory pins. The cycle has four parts. A setup phase presents the address, chip enable and byte lanes. A strobe phase pulses write enable, or holds output enable low for a read. A hold or turnaround phase lets the memory finish or let go of the bus. The controller then returns to idle, where it accepts the next request.

Every interval on the memory side is given in nanoseconds and turned into whole clock cycles by rounding up at the clock period parameter. The lengths covered are: address setup, write pulse, data setup, total write cycle, bus release after write enable, address-to-data, output-enable-to-data and bus release after output enable. A build option keeps output enable low through writes. In that mode the write pulse grows to cover the memory's bus release, and the data drivers turn on only after the memory has let go of the bus. Read data and the memory's correction flag are sampled together and returned with a single-cycle valid pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is all ones, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: `req_ready` is high only while idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. A request held valid during a busy cycle produces no second access.
- R3: A write (`req_write`=1) runs one setup cycle, then a write-enable low pulse of ceil(max(write pulse, data setup)) cycles, then at least one hold cycle. The total is at least ceil(write cycle) cycles, which gives 1, 4 and 1 cycles at a 10 ns clock. Write enable is never low unless chip enable is low.
- R4: While an access is active, `mem_be_n[1]` is low exactly when `req_bmask[1]` was set (upper byte, data bits 15:8), and `mem_be_n[0]` is low exactly when `req_bmask[0]` was set (lower byte, bits 7:0). Only enabled bytes are changed, and a mask of 00 leaves the word unchanged.
- R5: During a write, the address stays constant from setup through hold. The data bus is driven for at least ceil(data setup) cycles before write enable rises.
- R6: A read (`req_write`=0) runs one setup cycle with output enable high, then holds output enable low for max(ceil(address-to-data) - 1, ceil(oe-to-data)) cycles, which is 4 at defaults. Data is sampled at the end of the last of those cycles, and `rsp_valid` pulses for one cycle right after. Bytes whose mask bit is clear return as zero.
- R7: `rsp_err` returns the value of `mem_err` sampled on the same edge as the read data.
- R8: After a read, output enable stays high for ceil(output release) cycles (2 at defaults) before the block is idle again. The controller never drives the bus while the memory may be driving it.
- R9: With `WRITE_OE_LOW`=1, output enable stays low for the whole write. The write pulse is ceil(max(write pulse, data setup + write-enable release)) cycles, which is 5 at defaults. The data drivers turn on only after ceil(write-enable release) cycles of the pulse (2) and turn off when write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lane mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| rsp_err | output | 1 | Correction flag sampled with the read data |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |
| mem_dq_in | input | 16 | Data from the memory pads |
| mem_err | input | 1 | Correction indication from the memory |

## Verification
The assertions assume that the memory drives `mem_dq_in` and `mem_err` only when output enable is low and write enable is high. They also assume that the request fields stay steady in the cycle the request is taken. The responder in the bench returns stored data only under that strobe combination and commits a write on the rising edge of write enable. The request tasks change inputs only on falling clock edges, while the controller is idle. One of them deliberately keeps `req_valid` high through a busy cycle to test that the request is not taken a second time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } ctrl_state_e;

  // whole clock cycles covering a nanosecond interval
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      stage_q   <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      stage_q   <= 1'b1;
      rst_out_n <= stage_q;
    end
  end
endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_nxt,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign expired = (cnt_q == '0);
  assign cnt_en  = load || !expired;

  always_comb begin
    if (load)         cnt_nxt = load_val;
    else if (!expired) cnt_nxt = cnt_q - 1'b1;
    else              cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int BYTES        = 2,
  parameter int CLK_NS       = 10,
  parameter int T_AS_NS      = 0,
  parameter int T_WP_NS      = 35,
  parameter int T_DS_NS      = 25,
  parameter int T_WC_NS      = 45,
  parameter int T_HZWE_NS    = 18,
  parameter int T_AA_NS      = 45,
  parameter int T_DOE_NS     = 22,
  parameter int T_HZOE_NS    = 18,
  parameter bit WRITE_OE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BYTES-1:0] req_bmask,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic [BYTES-1:0] bmask,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [BYTES-1:0] mem_be_n,
  output logic             mem_dq_oe
);
  localparam int HZWE_C    = ns_to_cyc(T_HZWE_NS, CLK_NS);
  localparam int DS_C      = ns_to_cyc(T_DS_NS, CLK_NS);
  localparam int WR_SETUP  = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
  localparam int WR_PULSE  = WRITE_OE_LOW ?
                             imax(ns_to_cyc(T_WP_NS, CLK_NS), DS_C + HZWE_C) :
                             imax(1, imax(ns_to_cyc(T_WP_NS, CLK_NS), DS_C));
  localparam int WR_HOLD   = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - WR_SETUP - WR_PULSE);
  localparam int RD_SETUP  = 1;
  localparam int RD_ACCESS = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_NS) - RD_SETUP,
                                          ns_to_cyc(T_DOE_NS, CLK_NS)));
  localparam int RD_TURN   = imax(1, ns_to_cyc(T_HZOE_NS, CLK_NS));
  localparam int MAX_LEN   = imax(imax(imax(WR_SETUP, WR_PULSE), WR_HOLD),
                                  imax(RD_ACCESS, RD_TURN));
  localparam int CW        = imax(1, $clog2(MAX_LEN));
  // counter value from which the pads may drive inside a pulse with OE low
  localparam int DRIVE_AT  = imax(0, WR_PULSE - 1 - HZWE_C);

  ctrl_state_e      state_q, state_d;
  logic             op_wr_q, op_wr_d;
  logic [BYTES-1:0] mask_q, mask_d;
  logic             t_load, t_expired;
  logic [CW-1:0]    t_load_val, t_cnt_nxt;

  logic             ce_n_d, we_n_d, oe_n_d, dq_oe_d;
  logic [BYTES-1:0] be_n_d;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_load_val),
    .cnt_nxt  (t_cnt_nxt),
    .expired  (t_expired)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign capture   = (state_q == ST_ACTIVE) && !op_wr_q && t_expired;
  assign bmask     = mask_q;

  // next state
  always_comb begin
    state_d    = state_q;
    op_wr_d    = op_wr_q;
    mask_d     = mask_q;
    accept     = 1'b0;
    t_load     = 1'b0;
    t_load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept     = 1'b1;
        op_wr_d    = req_write;
        mask_d     = req_bmask;
        state_d    = ST_SETUP;
        t_load     = 1'b1;
        t_load_val = req_write ? CW'(WR_SETUP - 1) : CW'(RD_SETUP - 1);
      end
      ST_SETUP: if (t_expired) begin
        state_d    = ST_ACTIVE;
        t_load     = 1'b1;
        t_load_val = op_wr_q ? CW'(WR_PULSE - 1) : CW'(RD_ACCESS - 1);
      end
      ST_ACTIVE: if (t_expired) begin
        state_d    = ST_HOLD;
        t_load     = 1'b1;
        t_load_val = op_wr_q ? CW'(WR_HOLD - 1) : CW'(RD_TURN - 1);
      end
      ST_HOLD: if (t_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobe decode from the next state, registered below
  always_comb begin
    ce_n_d  = 1'b1;
    we_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    be_n_d  = '1;
    dq_oe_d = 1'b0;
    if (state_d != ST_IDLE) begin
      ce_n_d = 1'b0;
      be_n_d = ~mask_d;
      if (op_wr_d) begin
        we_n_d = (state_d != ST_ACTIVE);
        if (WRITE_OE_LOW) begin
          oe_n_d  = 1'b0;
          dq_oe_d = (state_d == ST_ACTIVE) && (t_cnt_nxt <= CW'(DRIVE_AT));
        end else begin
          dq_oe_d = 1'b1;
        end
      end else begin
        oe_n_d = (state_d != ST_ACTIVE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_wr_q   <= 1'b0;
      mask_q    <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_be_n  <= '1;
      mem_dq_oe <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (accept) begin
        op_wr_q <= op_wr_d;
        mask_q  <= mask_d;
      end
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_be_n  <= be_n_d;
      mem_dq_oe <= dq_oe_d;
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);                                      // R3
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n || !mem_we_n));                        // R8
  AST_DATA_AT_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $past(mem_dq_oe));                         // R5
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));           // R2
  AST_LANES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_be_n));        // R4
  AST_READ_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_we_n && !mem_dq_oe) |-> !req_ready);         // R6
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 10,
  parameter int T_AS_NS      = 0,
  parameter int T_WP_NS      = 35,
  parameter int T_DS_NS      = 25,
  parameter int T_WC_NS      = 45,
  parameter int T_HZWE_NS    = 18,
  parameter int T_AA_NS      = 45,
  parameter int T_DOE_NS     = 22,
  parameter int T_HZOE_NS    = 18,
  parameter bit WRITE_OE_LOW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_bmask,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_ce_n,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic [DATA_W/8-1:0]  mem_be_n,
  output logic [DATA_W-1:0]    mem_dq_out,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_in,
  input  logic                 mem_err
);
  localparam int BYTES = DATA_W / 8;

  logic             rst_sync_n;
  logic             accept, capture;
  logic [BYTES-1:0] bmask;
  logic [DATA_W-1:0] lane_bits;

  sram_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  sram_ctrl_fsm #(
    .BYTES(BYTES), .CLK_NS(CLK_NS), .T_AS_NS(T_AS_NS), .T_WP_NS(T_WP_NS),
    .T_DS_NS(T_DS_NS), .T_WC_NS(T_WC_NS), .T_HZWE_NS(T_HZWE_NS),
    .T_AA_NS(T_AA_NS), .T_DOE_NS(T_DOE_NS), .T_HZOE_NS(T_HZOE_NS),
    .WRITE_OE_LOW(WRITE_OE_LOW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_bmask (req_bmask),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .bmask     (bmask),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
  );

  // expand the byte mask to a bit mask for returned data
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lane_bits[b*8 +: 8] = {8{bmask[b]}};
  end

  // request fields held for the whole access
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // read capture and completion pulse
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_rdata <= mem_dq_in & lane_bits;
        rsp_err   <= mem_err;
      end
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> !rsp_valid);                                     // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));        // R5
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));      // R5
endmodule

// File: tb/sram_strobe_ctrl_test.sv
module sram_strobe_ctrl_test;
  localparam int CLK_PERIOD = 10;
  // expected cycle counts at a 10 ns clock, from the requirements
  localparam int E_WR_BUSY = 6;
  localparam int E_WP      = 4;
  localparam int E_DS      = 3;
  localparam int E_RD_BUSY = 7;
  localparam int E_RD_OE   = 4;
  localparam int E_TURN    = 2;
  localparam int E_OL_WP   = 5;
  localparam int E_OL_DLY  = 2;
  localparam int E_OL_BUSY = 7;

  logic clk, rst_n;
  logic req_valid, o_valid, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;

  logic        req_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata, m_dq_out, m_dq_in;
  logic [17:0] m_addr;
  logic        m_ce_n, m_we_n, m_oe_n, m_dq_oe, m_err;
  logic [1:0]  m_be_n;

  logic        o_ready, o_rsp_valid, o_rsp_err;
  logic [15:0] o_rsp_rdata, o_dq_out;
  logic [17:0] o_addr;
  logic        o_ce_n, o_we_n, o_oe_n, o_dq_oe;
  logic [1:0]  o_be_n;

  logic [15:0] mem [0:15];
  logic [17:0] err_addr;
  logic [15:0] wr_d;
  logic [1:0]  wr_be;
  logic [3:0]  wr_a;
  logic        prev_we;

  int total, bad;
  int r_busy, r_we, r_we_pulses, r_oe, r_pre_oe, r_turn, r_ds, r_fight;
  int r_addr_bad, r_be_bad, r_rsp, r_rsp_at, r_err;
  logic [15:0] r_rdata;
  int ol_busy, ol_we, ol_dly, ol_dq_we, ol_dq_high, ol_oe_high;

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_addr(m_addr), .mem_ce_n(m_ce_n), .mem_we_n(m_we_n),
    .mem_oe_n(m_oe_n), .mem_be_n(m_be_n), .mem_dq_out(m_dq_out),
    .mem_dq_oe(m_dq_oe), .mem_dq_in(m_dq_in), .mem_err(m_err));

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD), .WRITE_OE_LOW(1'b1)) uut_ol (
    .clk(clk), .rst_n(rst_n), .req_valid(o_valid), .req_ready(o_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(o_rsp_valid), .rsp_rdata(o_rsp_rdata),
    .rsp_err(o_rsp_err), .mem_addr(o_addr), .mem_ce_n(o_ce_n), .mem_we_n(o_we_n),
    .mem_oe_n(o_oe_n), .mem_be_n(o_be_n), .mem_dq_out(o_dq_out),
    .mem_dq_oe(o_dq_oe), .mem_dq_in(16'h0000), .mem_err(1'b0));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory responder
  assign m_dq_in = (!m_ce_n && !m_oe_n && m_we_n) ? mem[m_addr[3:0]] : 16'h0000;
  assign m_err   = !m_ce_n && !m_oe_n && m_we_n && (m_addr == err_addr);

  always @(negedge clk) begin
    if (!m_ce_n && !m_we_n && m_dq_oe) begin
      wr_d = m_dq_out; wr_be = m_be_n; wr_a = m_addr[3:0];
    end
    if (m_we_n && !prev_we) begin
      if (!wr_be[0]) mem[wr_a][7:0]  = wr_d[7:0];
      if (!wr_be[1]) mem[wr_a][15:8] = wr_d[15:8];
    end
    prev_we = m_we_n;
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input int act, input int lim, input string tag);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
    end
  endtask

  task automatic run_op(input logic wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic keep);
    logic oe_seen, pw;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    r_busy = 0; r_we = 0; r_we_pulses = 0; r_oe = 0; r_pre_oe = 0; r_turn = 0;
    r_ds = 0; r_fight = 0; r_addr_bad = 0; r_be_bad = 0; r_rsp = 0; r_rsp_at = 0;
    r_err = 0; r_rdata = '0;
    oe_seen = 1'b0; pw = 1'b1;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (!keep) req_valid = 1'b0;
      if (req_ready) begin
        req_valid = 1'b0;
        break;
      end
      r_busy++;
      if (!m_we_n) r_we++;
      if (!m_we_n && pw) r_we_pulses++;
      pw = m_we_n;
      if (!m_oe_n) begin
        r_oe++; oe_seen = 1'b1;
      end else if (oe_seen) begin
        r_turn++;
        if (m_dq_oe) r_fight++;
      end else begin
        r_pre_oe++;
      end
      if (m_dq_oe && !m_we_n) r_ds++;
      if (m_dq_oe && !m_oe_n) r_fight++;
      if (m_addr != a) r_addr_bad++;
      if (m_be_n != ~m) r_be_bad++;
      if (rsp_valid) begin
        r_rsp++; r_rsp_at = r_busy; r_rdata = rsp_rdata; r_err = int'(rsp_err);
      end
    end
  endtask

  task automatic t_reset;
    chk(int'(req_ready), 1, "R1 ready");
    chk(int'(m_ce_n), 1, "R1 ce_n");
    chk(int'(m_we_n), 1, "R1 we_n");
    chk(int'(m_oe_n), 1, "R1 oe_n");
    chk(int'(m_be_n), 3, "R1 be_n");
    chk(int'(m_dq_oe), 0, "R1 dq_oe");
    chk(int'(rsp_valid), 0, "R1 rsp_valid");
  endtask

  task automatic t_word;
    run_op(1'b1, 18'h00003, 16'hBEEF, 2'b11, 1'b0);
    chk(r_busy, E_WR_BUSY, "R3 write length");
    chk(r_we, E_WP, "R3 we pulse");
    chk(r_we_pulses, 1, "R3 one pulse");
    chk_ge(r_ds, E_DS, "R5 data setup");
    chk(r_addr_bad, 0, "R5 addr stable");
    chk(r_be_bad, 0, "R4 lanes on write");
    run_op(1'b0, 18'h00003, 16'h0000, 2'b11, 1'b0);
    chk(r_busy, E_RD_BUSY, "R6 read length");
    chk(r_oe, E_RD_OE, "R6 oe low cycles");
    chk(r_pre_oe, 1, "R6 read setup");
    chk(r_rsp, 1, "R6 one rsp pulse");
    chk(r_rsp_at, 1 + E_RD_OE + 1, "R6 rsp timing");
    chk(int'(r_rdata), 16'hBEEF, "R6 read data");
    chk(r_err, 0, "R7 no error");
    chk(r_turn, E_TURN, "R8 turnaround");
    chk(r_fight, 0, "R8 no drive");
  endtask

  task automatic t_bytes;
    run_op(1'b1, 18'h00005, 16'h1234, 2'b11, 1'b0);
    run_op(1'b1, 18'h00005, 16'hABCD, 2'b01, 1'b0);
    chk(r_be_bad, 0, "R4 lower lane only");
    run_op(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b0);
    chk(int'(r_rdata), 16'h12CD, "R4 lower byte write");
    run_op(1'b1, 18'h00005, 16'h5699, 2'b10, 1'b0);
    run_op(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b0);
    chk(int'(r_rdata), 16'h56CD, "R4 upper byte write");
    run_op(1'b1, 18'h00003, 16'h0000, 2'b00, 1'b0);
    chk(r_be_bad, 0, "R4 no lanes");
    run_op(1'b0, 18'h00003, 16'h0000, 2'b11, 1'b0);
    chk(int'(r_rdata), 16'hBEEF, "R4 empty mask keeps word");
  endtask

  task automatic t_masked_read;
    run_op(1'b0, 18'h00005, 16'h0000, 2'b10, 1'b0);
    chk(int'(r_rdata), 16'h5600, "R6 upper lane read");
    chk(r_be_bad, 0, "R4 lanes on read");
    run_op(1'b0, 18'h00005, 16'h0000, 2'b01, 1'b0);
    chk(int'(r_rdata), 16'h00CD, "R6 lower lane read");
  endtask

  task automatic t_err_flag;
    err_addr = 18'h00005;
    run_op(1'b0, 18'h00005, 16'h0000, 2'b11, 1'b0);
    chk(r_err, 1, "R7 flag set");
    chk(int'(r_rdata), 16'h56CD, "R7 data with flag");
    run_op(1'b0, 18'h00003, 16'h0000, 2'b11, 1'b0);
    chk(r_err, 0, "R7 flag clear");
    err_addr = 18'h3FFFF;
  endtask

  task automatic t_busy_hold;
    run_op(1'b1, 18'h00007, 16'h7777, 2'b11, 1'b1);
    chk(r_we_pulses, 1, "R2 single access");
    chk(r_busy, E_WR_BUSY, "R2 busy length");
    @(negedge clk);
    chk(int'(m_ce_n), 1, "R2 no second access");
    run_op(1'b0, 18'h00007, 16'h0000, 2'b11, 1'b0);
    chk(int'(r_rdata), 16'h7777, "R2 data after hold");
  endtask

  task automatic t_oe_low_write;
    logic started;
    @(negedge clk);
    o_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00009; req_wdata = 16'h3C3C;
    req_bmask = 2'b11;
    ol_busy = 0; ol_we = 0; ol_dly = 0; ol_dq_we = 0; ol_dq_high = 0; ol_oe_high = 0;
    started = 1'b0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      o_valid = 1'b0;
      if (o_ready) break;
      ol_busy++;
      if (o_oe_n) ol_oe_high++;
      if (!o_we_n) ol_we++;
      if (o_dq_oe) started = 1'b1;
      if (!o_we_n && !started) ol_dly++;
      if (!o_we_n && o_dq_oe) ol_dq_we++;
      if (o_we_n && o_dq_oe) ol_dq_high++;
    end
    chk(ol_we, E_OL_WP, "R9 stretched pulse");
    chk(ol_dly, E_OL_DLY, "R9 drive delay");
    chk_ge(ol_dq_we, E_DS, "R9 data setup");
    chk(ol_dq_high, 0, "R9 release at we rise");
    chk(ol_oe_high, 0, "R9 oe held low");
    chk(ol_busy, E_OL_BUSY, "R9 write length");
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; req_valid = 1'b0; o_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_bmask = '0;
    err_addr = 18'h3FFFF; prev_we = 1'b1;
    wr_d = '0; wr_be = '1; wr_a = '0;
    for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_word;
    t_bytes;
    t_masked_read;
    t_err_flag;
    t_busy_hold;
    t_oe_low_write;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule